// File: doc/BRIEF.md
# Single-Shunt Phase Current Reconstruction

This block rebuilds the three motor phase currents from one DC-link current sensor. In every PWM period the ADC delivers two DC-link samples, each taken during an active switching vector. Every sample arrives with the 3-bit upper-switch state of the bridge at that moment and with its own valid strobe. The block works out which phase each sample belongs to, and with what sign. It then derives the third phase from the rule that the three phase currents sum to zero.

DC-link current counts as positive when it flows into the positive bus terminal of the bridge and out of its negative terminal. When a single upper switch is on, the DC-link current flows out through that phase into the motor. When a single lower switch is on, the DC-link current returns through that phase, so the phase current is the negated sample. Each sample is left-aligned by `ALIGN_SH` bits into a wider signed output word, and every output saturates at the limits of that word. Zero vectors and pairs that resolve to the same phase never disturb the outputs.

Top module: `sshuntRecon`

## Requirements
- R1: Upper-switch state bit 0 is phase A, bit 1 is phase B and bit 2 is phase C, with a 1 meaning the upper switch is on. The states 001, 010 and 100 assign their sample to phase A, B or C respectively, with a positive sign. The output value is the sample multiplied by 2^ALIGN_SH, which is 16 at the defaults.
- R2: The states 110, 101 and 011 (a single lower switch on) assign the negated sample to phase A, B or C respectively, also scaled by 2^ALIGN_SH.
- R3: A sample tagged 000 or 111 is invalid. A pair that contains such a sample leaves all three outputs unchanged, keeps outVld at 0 and does not raise errPulse.
- R4: The phase that neither sample covers is output as the negated sum of the two measured phase values.
- R5: If both samples resolve to the same phase, the outputs keep their previous values, outVld stays 0, and errPulse is high for exactly one cycle.
- R6: Each output saturates to the range -32768 to 32767 (OUT_W = 16) instead of wrapping.
- R7: A sample is captured on the clock edge where its strobe is high. The outputs and a one-cycle outVld appear on the following edge, once both slots hold a sample. A pair is consumed when it is evaluated, valid or not.
- R8: The two samples may arrive in the same cycle or in separate cycles, in either order. A second strobe on a slot that already holds a sample, before the pair is evaluated, replaces that sample.
- R9: After reset, the outputs are 0 and outVld and errPulse are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| aVld | input | 1 | Strobe for the first sample slot |
| aData | input | 12 | First DC-link sample, signed |
| aState | input | 3 | Upper-switch state at the first sample |
| bVld | input | 1 | Strobe for the second sample slot |
| bData | input | 12 | Second DC-link sample, signed |
| bState | input | 3 | Upper-switch state at the second sample |
| iaOut | output | 16 | Phase A current, signed |
| ibOut | output | 16 | Phase B current, signed |
| icOut | output | 16 | Phase C current, signed |
| outVld | output | 1 | One-cycle strobe marking updated outputs |
| errPulse | output | 1 | One-cycle pulse for a pair that resolves to a single phase |

## Verification
Two functions can coincide in the same cycle. Saturation of a directly measured phase can fall on the same update as saturation of the derived phase. This is provoked with full-scale samples whose negated or summed values overflow the 16-bit word, and it is judged by checking all three rails at once. Separately, capturing a sample and evaluating the previous pair can fall on the same edge, so a replaced slot is checked to make sure the newest sample wins. Error pulses and invalid pairs are judged at the ports: the outputs must be unchanged and the strobes must be correct.

// File: rtl/sshunt_pkg.sv
package sshunt_pkg;

  typedef enum logic [1:0] {
    PH_A    = 2'd0,
    PH_B    = 2'd1,
    PH_C    = 2'd2,
    PH_NONE = 2'd3
  } phase_e;

  // Result of classifying one switching vector
  typedef struct packed {
    logic   ok;    // active vector with a single switch isolated
    phase_e ph;    // phase the DC-link current belongs to
    logic   neg;   // phase current is the negated sample
  } vec_dec_t;

  localparam int NSLOT = 2;

  // Strobes from control to datapath
  typedef struct packed {
    logic [NSLOT-1:0]           cap;   // latch sample per slot
    logic                       load;  // write new phase currents
    vec_dec_t [NSLOT-1:0]       dec;   // classification of each held slot
  } ctl_t;

  // Bit i of the state is the upper switch of phase i
  function automatic vec_dec_t decodeVec(input logic [2:0] upOn);
    vec_dec_t d;
    unique case (upOn)
      3'b001:  d = '{ok: 1'b1, ph: PH_A, neg: 1'b0};
      3'b010:  d = '{ok: 1'b1, ph: PH_B, neg: 1'b0};
      3'b100:  d = '{ok: 1'b1, ph: PH_C, neg: 1'b0};
      3'b110:  d = '{ok: 1'b1, ph: PH_A, neg: 1'b1};
      3'b101:  d = '{ok: 1'b1, ph: PH_B, neg: 1'b1};
      3'b011:  d = '{ok: 1'b1, ph: PH_C, neg: 1'b1};
      default: d = '{ok: 1'b0, ph: PH_NONE, neg: 1'b0};
    endcase
    return d;
  endfunction

endpackage

// File: rtl/sshunt_ctrl.sv
module sshunt_ctrl
  import sshunt_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NSLOT-1:0]      smpVld,
  input  logic [NSLOT-1:0][2:0] smpState,
  output ctl_t                  ctl,
  output logic                  errPulse
);

  logic     full [NSLOT];
  vec_dec_t decQ [NSLOT];
  logic     evalNow;
  logic     pairOk;
  logic     clash;
  logic     errQ;

  assign evalNow = full[0] && full[1];
  assign pairOk  = decQ[0].ok && decQ[1].ok;
  assign clash   = pairOk && (decQ[0].ph == decQ[1].ph);

  // One holding slot per sample stream
  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        full[s] <= 1'b0;
        decQ[s] <= '{ok: 1'b0, ph: PH_NONE, neg: 1'b0};
      end else if (smpVld[s]) begin
        full[s] <= 1'b1;
        decQ[s] <= decodeVec(smpState[s]);
      end else if (evalNow) begin
        full[s] <= 1'b0;
      end
    end

    // R7: an evaluated slot is empty afterwards unless refilled
    p_slot_consumed_r7: assert property (@(posedge clk) disable iff (!rstN)
      (evalNow && !smpVld[s]) |=> !full[s]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) errQ <= 1'b0;
    else       errQ <= evalNow && clash;
  end

  always_comb begin
    ctl.cap  = smpVld;
    ctl.load = evalNow && pairOk && !clash;
    for (int s = 0; s < NSLOT; s++) ctl.dec[s] = decQ[s];
  end

  assign errPulse = errQ;

  // R3: a slot holding a zero vector never produces an update
  p_zero_vec_blocks_r3: assert property (@(posedge clk) disable iff (!rstN)
    (full[0] && (decQ[0].ph == PH_NONE)) |-> !ctl.load);

endmodule

// File: rtl/sshunt_dp.sv
module sshunt_dp
  import sshunt_pkg::*;
#(
  parameter int SMP_W    = 12,
  parameter int OUT_W    = 16,
  parameter int ALIGN_SH = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctl_t                        ctl,
  input  logic [NSLOT-1:0][SMP_W-1:0] smpData,
  output logic [2:0][OUT_W-1:0]       curOut,
  output logic                        curVld
);

  localparam int RAW_W = SMP_W + ALIGN_SH + 2;
  localparam int EXT_W = (RAW_W > OUT_W) ? RAW_W : OUT_W + 1;
  localparam logic signed [EXT_W-1:0] SAT_HI = EXT_W'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
  localparam logic signed [EXT_W-1:0] SAT_LO = -SAT_HI - EXT_W'(1);
  localparam logic [OUT_W-1:0] RAIL_HI = SAT_HI[OUT_W-1:0];
  localparam logic [OUT_W-1:0] RAIL_LO = SAT_LO[OUT_W-1:0];

  logic        [SMP_W-1:0] smpQ  [NSLOT];
  logic signed [EXT_W-1:0] term  [NSLOT];
  logic signed [EXT_W-1:0] pairSum;
  logic signed [EXT_W-1:0] raw   [3];
  logic        [OUT_W-1:0] satV  [3];
  logic        [OUT_W-1:0] curQ  [3];
  logic                    vldQ;

  function automatic logic [OUT_W-1:0] clampTo(input logic signed [EXT_W-1:0] v);
    if (v > SAT_HI)      return SAT_HI[OUT_W-1:0];
    else if (v < SAT_LO) return SAT_LO[OUT_W-1:0];
    else                 return v[OUT_W-1:0];
  endfunction

  // Sample holding, sign and alignment per slot
  for (genvar s = 0; s < NSLOT; s++) begin : g_term
    logic signed [EXT_W-1:0] ext;
    logic signed [EXT_W-1:0] mag;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          smpQ[s] <= '0;
      else if (ctl.cap[s]) smpQ[s] <= smpData[s];
    end

    always_comb begin
      ext     = EXT_W'($signed(smpQ[s]));
      mag     = ctl.dec[s].neg ? -ext : ext;
      term[s] = mag <<< ALIGN_SH;
    end
  end

  assign pairSum = term[0] + term[1];

  // Phase routing: measured phases take their sample, the rest is derived
  for (genvar p = 0; p < 3; p++) begin : g_phase
    logic hit0;
    logic hit1;

    assign hit0 = (ctl.dec[0].ph == phase_e'(p));
    assign hit1 = (ctl.dec[1].ph == phase_e'(p));

    always_comb begin
      if (hit0)      raw[p] = term[0];
      else if (hit1) raw[p] = term[1];
      else           raw[p] = -pairSum;
      satV[p] = clampTo(raw[p]);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)         curQ[p] <= '0;
      else if (ctl.load) curQ[p] <= satV[p];
    end

    assign curOut[p] = curQ[p];

    // R6: a value beyond the word limits lands on the rail
    p_clamp_high_r6: assert property (@(posedge clk) disable iff (!rstN)
      (ctl.load && (raw[p] > SAT_HI)) |=> (curQ[p] == RAIL_HI));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) vldQ <= 1'b0;
    else       vldQ <= ctl.load;
  end

  assign curVld = vldQ;

  // R3, R5: outputs move only on an accepted pair
  p_hold_without_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> ($stable(curQ[0]) && $stable(curQ[1]) && $stable(curQ[2])));

  // R2, R1: an accepted pair always carries two classified slots
  p_load_needs_valid_r1: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |-> (ctl.dec[0].ok && ctl.dec[1].ok));

  // R4: unclamped outputs sum to zero
  p_zero_sum_r4: assert property (@(posedge clk) disable iff (!rstN)
    (vldQ && curQ[0] != RAIL_HI && curQ[0] != RAIL_LO
          && curQ[1] != RAIL_HI && curQ[1] != RAIL_LO
          && curQ[2] != RAIL_HI && curQ[2] != RAIL_LO)
    |-> ((OUT_W + 2)'($signed(curQ[0])) + (OUT_W + 2)'($signed(curQ[1]))
         + (OUT_W + 2)'($signed(curQ[2])) == '0));

endmodule

// File: rtl/sshuntRecon.sv
module sshuntRecon
  import sshunt_pkg::*;
#(
  parameter int SMP_W    = 12,
  parameter int OUT_W    = 16,
  parameter int ALIGN_SH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             aVld,
  input  logic [SMP_W-1:0] aData,
  input  logic [2:0]       aState,
  input  logic             bVld,
  input  logic [SMP_W-1:0] bData,
  input  logic [2:0]       bState,
  output logic [OUT_W-1:0] iaOut,
  output logic [OUT_W-1:0] ibOut,
  output logic [OUT_W-1:0] icOut,
  output logic             outVld,
  output logic             errPulse
);

  ctl_t                  ctl;
  logic [2:0][OUT_W-1:0] curOut;

  sshunt_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .smpVld   ({bVld, aVld}),
    .smpState ({bState, aState}),
    .ctl      (ctl),
    .errPulse (errPulse)
  );

  sshunt_dp #(
    .SMP_W    (SMP_W),
    .OUT_W    (OUT_W),
    .ALIGN_SH (ALIGN_SH)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .smpData ({bData, aData}),
    .curOut  (curOut),
    .curVld  (outVld)
  );

  assign iaOut = curOut[0];
  assign ibOut = curOut[1];
  assign icOut = curOut[2];

  // R5: an error pulse never accompanies an update
  p_err_excludes_update_r5: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> !outVld);

endmodule

// File: tb/tb_sshuntRecon.sv
module tb_sshuntRecon;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        aVld = 1'b0, bVld = 1'b0;
  logic [11:0] aData = '0, bData = '0;
  logic [2:0]  aState = '0, bState = '0;
  logic [15:0] iaOut, ibOut, icOut;
  logic        outVld, errPulse;

  int nChecks = 0;
  int nFails  = 0;
  int expA = 0, expB = 0, expC = 0;   // last accepted outputs

  always #4 clk = ~clk;   // 125 MHz

  sshuntRecon dut (
    .clk(clk), .rstN(rstN),
    .aVld(aVld), .aData(aData), .aState(aState),
    .bVld(bVld), .bData(bData), .bState(bState),
    .iaOut(iaOut), .ibOut(ibOut), .icOut(icOut),
    .outVld(outVld), .errPulse(errPulse)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int clamp16(input int v);
    if (v > 32767)  return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  // Phase index (0..2) and sign of a state; -1 for a zero vector
  function automatic int phaseOf(input logic [2:0] st, output int sgn);
    sgn = 1;
    case (st)
      3'b001: return 0;
      3'b010: return 1;
      3'b100: return 2;
      3'b110: begin sgn = -1; return 0; end
      3'b101: begin sgn = -1; return 1; end
      3'b011: begin sgn = -1; return 2; end
      default: return -1;
    endcase
  endfunction

  // Expected currents for a valid, non-clashing pair
  task automatic model(input logic [2:0] s0, input int d0,
                       input logic [2:0] s1, input int d1);
    int v[3];
    int g0, g1, p0, p1, m0, m1;
    p0 = phaseOf(s0, g0);
    p1 = phaseOf(s1, g1);
    m0 = g0 * d0 * 16;
    m1 = g1 * d1 * 16;
    for (int p = 0; p < 3; p++) v[p] = -(m0 + m1);
    v[p0] = m0;
    v[p1] = m1;
    expA = clamp16(v[0]);
    expB = clamp16(v[1]);
    expC = clamp16(v[2]);
  endtask

  task automatic sendBoth(input logic [2:0] s0, input int d0,
                          input logic [2:0] s1, input int d1);
    @(negedge clk);
    aVld = 1'b1; aState = s0; aData = 12'(d0);
    bVld = 1'b1; bState = s1; bData = 12'(d1);
    @(negedge clk);
    aVld = 1'b0; bVld = 1'b0;
  endtask

  task automatic sendOne(input int slot, input logic [2:0] s, input int d);
    @(negedge clk);
    if (slot == 0) begin aVld = 1'b1; aState = s; aData = 12'(d); end
    else           begin bVld = 1'b1; bState = s; bData = 12'(d); end
    @(negedge clk);
    aVld = 1'b0; bVld = 1'b0;
  endtask

  task automatic checkOut(input string tag, input int vld, input int err);
    chk({tag, " ia"}, int'($signed(iaOut)), expA);
    chk({tag, " ib"}, int'($signed(ibOut)), expB);
    chk({tag, " ic"}, int'($signed(icOut)), expC);
    chk({tag, " outVld"}, int'(outVld), vld);
    chk({tag, " errPulse"}, int'(errPulse), err);
  endtask

  task automatic tReset;
    checkOut("R9 reset", 0, 0);
  endtask

  task automatic tUpperPositive;
    sendBoth(3'b001, 300, 3'b100, -120);
    @(negedge clk);
    model(3'b001, 300, 3'b100, -120);
    checkOut("R1 R4 R7 upper A,C", 1, 0);
    sendBoth(3'b010, 1000, 3'b001, 55);
    @(negedge clk);
    model(3'b010, 1000, 3'b001, 55);
    checkOut("R1 R4 upper B,A", 1, 0);
    @(negedge clk);
    chk("R7 outVld one cycle", int'(outVld), 0);
  endtask

  task automatic tLowerNegative;
    sendBoth(3'b110, 250, 3'b011, -400);
    @(negedge clk);
    model(3'b110, 250, 3'b011, -400);
    checkOut("R2 R4 lower A,C", 1, 0);
    sendBoth(3'b101, 777, 3'b100, 100);
    @(negedge clk);
    model(3'b101, 777, 3'b100, 100);
    checkOut("R2 lower B mixed", 1, 0);
  endtask

  task automatic tSplitArrival;
    sendOne(1, 3'b100, 50);
    chk("R8 single slot no update", int'(outVld), 0);
    sendOne(0, 3'b001, 100);
    sendOne(0, 3'b010, 200);   // replaces slot A before evaluation? no: pair already full
    model(3'b001, 100, 3'b100, 50);
    checkOut("R8 order B then A", 0, 0);
    // slot A now holds 010/200 and waits; slot B refilled below
    sendOne(1, 3'b100, 60);
    @(negedge clk);
    model(3'b010, 200, 3'b100, 60);
    checkOut("R8 queued sample pairs next", 1, 0);
    sendOne(0, 3'b001, 11);
    sendOne(0, 3'b011, 22);    // overwrite before B arrives
    sendOne(1, 3'b010, 33);
    @(negedge clk);
    model(3'b011, 22, 3'b010, 33);
    checkOut("R8 overwrite keeps newest", 1, 0);
  endtask

  task automatic tZeroVector;
    sendBoth(3'b000, 500, 3'b001, 40);
    @(negedge clk);
    checkOut("R3 zero vector 000", 0, 0);
    sendBoth(3'b010, 40, 3'b111, 500);
    @(negedge clk);
    checkOut("R3 zero vector 111", 0, 0);
    sendBoth(3'b100, 7, 3'b010, -9);
    @(negedge clk);
    model(3'b100, 7, 3'b010, -9);
    checkOut("R3 R7 recovery after invalid", 1, 0);
  endtask

  task automatic tSamePhase;
    sendBoth(3'b001, 123, 3'b110, 321);
    @(negedge clk);
    checkOut("R5 same phase", 0, 1);
    @(negedge clk);
    chk("R5 errPulse one cycle", int'(errPulse), 0);
  endtask

  task automatic tSaturate;
    sendBoth(3'b110, -2048, 3'b010, 2047);
    @(negedge clk);
    model(3'b110, -2048, 3'b010, 2047);
    checkOut("R6 measured and derived clamp", 1, 0);
    sendBoth(3'b011, 2047, 3'b101, 2047);
    @(negedge clk);
    model(3'b011, 2047, 3'b101, 2047);
    checkOut("R6 derived positive clamp", 1, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tUpperPositive();
    tLowerNegative();
    tSplitArrival();
    tZeroVector();
    tSamePhase();
    tSaturate();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule